// File: doc/BRIEF.md
# Bidirectional-Bus Universal Shift Register

This block is a register of W flip-flops (eight by default) that can hold its contents, shift one place in either direction, or load a whole word in parallel. A two-bit mode input picks the operation, and the chosen operation takes effect on each rising clock edge. The parallel word moves in and out over a single shared bidirectional bus. The block drives that bus from its own register contents whenever it is allowed to, and it lets go of the bus whenever the mode is parallel load, so the same wires can carry data into the register.

Two disable inputs, both active high, can also take the bus drivers off. While the drivers are off, the register keeps working in every mode. A surrounding system can therefore prepare the contents while another agent owns the bus. Each end bit of the register also has its own output pin, and these pins are always driven. To build a longer shift chain, connect a block's end-bit output to the serial input of its neighbour. An active-low reset clears the register at once, without waiting for a clock edge.

Top module: `usr_shift_bidir`

## Requirements
- R1: When rst_n is low, every register bit is cleared immediately, with no clock edge needed. While rst_n stays low, the register stays zero whatever the clock and mode inputs do.
- R2: When mode_sel = 2'b00 (hold), the register keeps its value across a rising clock edge.
- R3: When mode_sel = 2'b01 (shift right), each rising edge moves bit i into bit i+1, and bit 0 takes ser_in_r.
- R4: When mode_sel = 2'b10 (shift left), each rising edge moves bit i+1 into bit i, and bit W-1 takes ser_in_l.
- R5: When mode_sel = 2'b11 (load), each rising edge copies the value on data_io into the register.
- R6: bus_drive is high exactly when bus_off_a and bus_off_b are both low and mode_sel is not 2'b11. While bus_drive is high, data_io shows the register contents, with bit i on data_io[i].
- R7: When bus_off_a or bus_off_b is high, bus_drive is low. Hold, shift and load still update the register as in R2 to R5.
- R8: ser_out_lo always equals register bit 0, and ser_out_hi always equals bit W-1. Both are driven in every mode and at every setting of the disables.
- R9: Two blocks can be chained into one 2W-bit shift register. Feed the lower block's ser_out_hi into the upper block's ser_in_r, and the upper block's ser_out_lo into the lower block's ser_in_l. The pair then shifts as one register in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous clear, active low |
| mode_sel | input | 2 | Operation select: 00 hold, 01 shift right, 10 shift left, 11 load |
| bus_off_a | input | 1 | Bus driver disable, active high |
| bus_off_b | input | 1 | Second bus driver disable, active high |
| ser_in_r | input | 1 | Serial input that enters bit 0 during a right shift |
| ser_in_l | input | 1 | Serial input that enters bit W-1 during a left shift |
| data_io | inout | W | Shared parallel bus: carries the register contents out, or the load data in |
| ser_out_lo | output | 1 | Always-driven copy of bit 0 |
| ser_out_hi | output | 1 | Always-driven copy of bit W-1 |
| bus_drive | output | 1 | High while the block is driving data_io |

## Verification
Two blocks are chained and loaded with asymmetric words such as 16'hA53C. With that data, a right shift can be told apart from a left shift, and a dropped or duplicated bit where the two blocks meet shows up immediately. Long shift runs feed alternating serial values and then constant ones, for more than sixteen cycles in each direction. These runs prove that the chain carries bits across the block boundary and out of the far end. The bus-disable inputs are raised one at a time during a shift and during a load. Lowering them afterwards shows, through the bus, that the register kept updating while the drivers were off. Reset is dropped between clock edges to separate an asynchronous clear from a synchronous one.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_SHR  = 2'b01,
    MODE_SHL  = 2'b10,
    MODE_LOAD = 2'b11
  } usr_mode_e;
endpackage

// File: rtl/usr_ctrl.sv
module usr_ctrl
  import usr_pkg::*;
(
  input  logic [1:0] mode_sel,
  input  logic       bus_off_a,
  input  logic       bus_off_b,
  output usr_mode_e  mode,
  output logic       drive_en
);
  always_comb begin
    mode     = usr_mode_e'(mode_sel);
    // The bus is released during load, so the pins can act as data inputs.
    drive_en = !bus_off_a && !bus_off_b && (mode != MODE_LOAD);
  end
endmodule

// File: rtl/usr_cell.sv
module usr_cell
  import usr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  usr_mode_e mode,
  input  logic      from_lo,
  input  logic      from_hi,
  input  logic      par_in,
  output logic      q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else begin
      case (mode)
        MODE_SHR:  q <= from_lo;
        MODE_SHL:  q <= from_hi;
        MODE_LOAD: q <= par_in;
        default:   q <= q;
      endcase
    end
  end
endmodule

// File: rtl/usr_shift_bidir.sv
module usr_shift_bidir
  import usr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode_sel,
  input  logic         bus_off_a,
  input  logic         bus_off_b,
  input  logic         ser_in_r,
  input  logic         ser_in_l,
  inout  wire  [W-1:0] data_io,
  output logic         ser_out_lo,
  output logic         ser_out_hi,
  output logic         bus_drive
);
  localparam int MSB = W - 1;

  usr_mode_e      mode;
  logic [MSB:0]   q;
  logic [MSB:0]   feed_r;
  logic [MSB:0]   feed_l;

  usr_ctrl u_ctrl (
    .mode_sel  (mode_sel),
    .bus_off_a (bus_off_a),
    .bus_off_b (bus_off_b),
    .mode      (mode),
    .drive_en  (bus_drive)
  );

  // Neighbour values seen by each bit, with the serial inputs at the ends.
  assign feed_r = {q[MSB-1:0], ser_in_r};
  assign feed_l = {ser_in_l, q[MSB:1]};

  for (genvar i = 0; i < W; i++) begin : g_bit
    usr_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode),
      .from_lo (feed_r[i]),
      .from_hi (feed_l[i]),
      .par_in  (data_io[i]),
      .q       (q[i])
    );
  end

  assign data_io    = bus_drive ? q : {W{1'bz}};
  assign ser_out_lo = q[0];
  assign ser_out_hi = q[MSB];
endmodule

// File: rtl/usr_shift_chk.sv
module usr_shift_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   mode_sel,
  input logic         bus_off_a,
  input logic         bus_off_b,
  input logic         ser_in_r,
  input logic         ser_in_l,
  input logic [W-1:0] data_io,
  input logic         ser_out_lo,
  input logic         ser_out_hi,
  input logic         bus_drive
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (!ser_out_lo && !ser_out_hi);
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00) |=> $stable({ser_out_hi, ser_out_lo}));

  assert_shr_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b01) |=> (ser_out_lo == $past(ser_in_r)));

  assert_shl_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b10) |=> (ser_out_hi == $past(ser_in_l)));

  assert_load_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b11) |-> !bus_drive);

  assert_bus_shows_reg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |-> (data_io[0] == ser_out_lo && data_io[W-1] == ser_out_hi));

  assert_off_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_off_a || bus_off_b) |-> !bus_drive);
endmodule

bind usr_shift_bidir usr_shift_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_sel   (mode_sel),
  .bus_off_a  (bus_off_a),
  .bus_off_b  (bus_off_b),
  .ser_in_r   (ser_in_r),
  .ser_in_l   (ser_in_l),
  .data_io    (data_io),
  .ser_out_lo (ser_out_lo),
  .ser_out_hi (ser_out_hi),
  .bus_drive  (bus_drive)
);

// File: tb/usr_shift_bidir_tb.sv
module usr_shift_bidir_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic [1:0] mode_sel = 2'b00;
  logic off_a = 1'b0, off_b = 1'b0;
  logic ext_sr = 1'b0, ext_sl = 1'b0;
  logic tb_drv = 1'b0;
  logic [W-1:0] lo_val = '0, hi_val = '0;

  wire [W-1:0] bus_lo, bus_hi;
  logic lo_so_lo, lo_so_hi, hi_so_lo, hi_so_hi, lo_drv, hi_drv;

  int n_tests = 0, n_fail = 0;
  logic [2*W-1:0] model = '0;
  string req = "R1";

  always #4 clk = ~clk;

  assign bus_lo = tb_drv ? lo_val : {W{1'bz}};
  assign bus_hi = tb_drv ? hi_val : {W{1'bz}};

  usr_shift_bidir #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .bus_off_a(off_a), .bus_off_b(off_b),
    .ser_in_r(ext_sr), .ser_in_l(hi_so_lo), .data_io(bus_lo),
    .ser_out_lo(lo_so_lo), .ser_out_hi(lo_so_hi), .bus_drive(lo_drv)
  );

  usr_shift_bidir #(.W(W)) u_hi (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .bus_off_a(off_a), .bus_off_b(off_b),
    .ser_in_r(lo_so_hi), .ser_in_l(ext_sl), .data_io(bus_hi),
    .ser_out_lo(hi_so_lo), .ser_out_hi(hi_so_hi), .bus_drive(hi_drv)
  );

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Compare every observable output against the model (sampled away from clk edges).
  task automatic compare();
    logic exp_drv;
    exp_drv = !off_a && !off_b && (mode_sel != 2'b11);
    check(lo_so_lo == model[0], req, "R8 low ser_out_lo", 32'(lo_so_lo), 32'(model[0]));
    check(lo_so_hi == model[W-1], req, "R8 low ser_out_hi", 32'(lo_so_hi), 32'(model[W-1]));
    check(hi_so_lo == model[W], req, "R9 high ser_out_lo", 32'(hi_so_lo), 32'(model[W]));
    check(hi_so_hi == model[2*W-1], req, "R9 high ser_out_hi", 32'(hi_so_hi), 32'(model[2*W-1]));
    check(lo_drv == exp_drv, req, "R6 bus_drive", 32'(lo_drv), 32'(exp_drv));
    check(hi_drv == exp_drv, req, "R6 bus_drive high", 32'(hi_drv), 32'(exp_drv));
    if (exp_drv && !tb_drv) begin
      check({bus_hi, bus_lo} == model, req, "R6 bus contents",
            32'({bus_hi, bus_lo}), 32'(model));
    end
  endtask

  // Apply one cycle of stimulus at a falling edge, step the model, compare after the rising edge.
  task automatic step(input logic [1:0] m, input logic sr, input logic sl,
                      input logic [2*W-1:0] ld, input logic oa, input logic ob);
    logic [2*W-1:0] nxt;
    mode_sel = m; ext_sr = sr; ext_sl = sl; off_a = oa; off_b = ob;
    tb_drv = (m == 2'b11);
    {hi_val, lo_val} = ld;
    #1;
    compare();
    case (m)
      2'b00: nxt = model;
      2'b01: nxt = {model[2*W-2:0], sr};
      2'b10: nxt = {sl, model[2*W-1:1]};
      default: nxt = ld;
    endcase
    if (!rst_n) nxt = '0;
    @(posedge clk);
    @(negedge clk);
    model = nxt;
    compare();
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    @(negedge clk);
    req = "R1";
    step(2'b11, 1'b1, 1'b1, 16'hFFFF, 1'b0, 1'b0);  // reset overrides load
    step(2'b01, 1'b1, 1'b1, 16'h0000, 1'b0, 1'b0);
    rst_n = 1'b1;

    req = "R5";
    step(2'b11, 1'b0, 1'b0, 16'hA53C, 1'b0, 1'b0);
    req = "R2";
    for (int k = 0; k < 3; k++) step(2'b00, 1'b1, 1'b1, 16'h0000, 1'b0, 1'b0);
    req = "R3";
    for (int k = 0; k < 18; k++) step(2'b01, k[0], 1'b0, 16'h0000, 1'b0, 1'b0);
    req = "R5";
    step(2'b11, 1'b0, 1'b0, 16'h8001, 1'b0, 1'b0);
    req = "R4";
    for (int k = 0; k < 18; k++) step(2'b10, 1'b0, (k % 3) == 0, 16'h0000, 1'b0, 1'b0);
    req = "R9";
    step(2'b11, 1'b0, 1'b0, 16'h0180, 1'b0, 1'b0);
    for (int k = 0; k < 9; k++) step(2'b01, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0);
    for (int k = 0; k < 9; k++) step(2'b10, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0);

    req = "R7";
    step(2'b01, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0);
    step(2'b01, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0);
    step(2'b11, 1'b0, 1'b0, 16'h5AC3, 1'b0, 1'b1);
    step(2'b10, 1'b0, 1'b1, 16'h0000, 1'b1, 1'b1);
    step(2'b00, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0);  // drivers back: bus reveals updates
    req = "R6";
    step(2'b11, 1'b0, 1'b0, 16'h1234, 1'b0, 1'b0);
    step(2'b00, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0);

    // R1: asynchronous clear between clock edges
    req = "R1";
    #1 rst_n = 1'b0;
    #1 model = '0;
    check({hi_so_hi, hi_so_lo, lo_so_hi, lo_so_lo} == 4'b0000, "R1", "async clear",
          32'({hi_so_hi, hi_so_lo, lo_so_hi, lo_so_lo}), 32'd0);
    check({bus_hi, bus_lo} == 16'h0000, "R1", "async clear bus",
          32'({bus_hi, bus_lo}), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    step(2'b00, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule